// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block sits in front of a bank of triple-channel counter chips. Each counter channel gets its own clock select code and gate select code, which software writes through a small register port. From these codes the block picks one signal per channel for the counter's clock input and one for its gate input. The candidate signals are:

- the channel's own clock and gate pins;
- a clock pin shared by the whole chip;
- six internal time bases;
- fixed levels;
- the outputs of neighbouring counter channels;
- three status flags from a pattern detector.

When a channel does not use its own pin, the pin turns into an output. The routed signal is then driven on it, and the block reports this on a per-pin output-enable.

Channels are numbered globally as chip × 3 + position. The clock chain input of a channel is the output of the channel one below it. The gate chain input is the output of the channel two below it. Both counts wrap from the lowest chip back to the highest, so the chips form a ring. An enhanced-mode input widens the set of codes that select a real source. A code with no meaning in the current mode routes a constant low. All routed values and pin enables are registered.

Top module: `counter_src_select`

## Requirements
- R1: While reset is high and right after it, every clock code and gate code is 0. `ctr_clk` is 0, `ctr_gate` is all ones, `clk_pin_oe` is 0 and `gat_pin_oe` is all ones.
- R2: Clock codes 0 to 7 pick, in order, the following sources:
  - 0: the channel's clock pin;
  - 1 to 5: the 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz time bases;
  - 6: the chained neighbour output;
  - 7: the chip's shared external clock, which is `ext_clk[g/3]`.
- R3: In enhanced mode, the following clock codes are defined:
  - 8: constant high;
  - 9: constant low;
  - 10: pattern-present;
  - 11: the 20 MHz time base.

  Clock codes 12 to 31 give low in every mode. Codes 8 to 31 give low when `enhanced` is 0.
- R4: Gate codes 0 to 3 give, in order:
  - 0: constant high;
  - 1: constant low;
  - 2: the channel's gate pin;
  - 3: the inverted chained output.
- R5: In enhanced mode, the following gate codes are defined:
  - 6: the inverted gate pin;
  - 7: the chained output;
  - 8 to 10: pattern-present, pattern-occurred and pattern-gone;
  - 11 to 13: the inverses of codes 8 to 10.

  Gate codes 4 and 5, and codes 14 to 31, give low. All gate codes from 4 upward give low when `enhanced` is 0.
- R6: The clock chain input of channel g is `ctr_out[(g-1) mod N]`, where N = 3 × NUM_CHIPS. For position 0 of a chip this is position 2 of the preceding chip. Chip 0 is preceded by the highest chip.
- R7: The gate chain input of channel g is `ctr_out[(g-2) mod N]`. For position 2 this is position 0 of the same chip. For positions 0 and 1 it is position n+1 of the preceding chip, with the same ring wrap as R6.
- R8: `clk_pin_oe[g]` is 1 exactly when the clock code of g is not 0. `gat_pin_oe[g]` is 1 exactly when the gate code of g is not 2.
- R9: `rd_code` returns the stored 5-bit code unchanged, including reserved and out-of-range values. It appears one cycle after `rd_chan` and `rd_gate` are presented. `rd_gate` = 1 selects the gate code.
- R10: `ctr_clk`, `ctr_gate` and both enable vectors are registered. A change on a source input or a code appears after exactly one rising edge.
- R11: A write with `wr_chan` ≥ N changes no code. A read with `rd_chan` ≥ N returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enhanced | input | 1 | Enables the widened code set |
| wr_en | input | 1 | Code write strobe |
| wr_gate | input | 1 | 1 writes the gate code, 0 the clock code |
| wr_chan | input | CH_W | Global channel index for the write |
| wr_code | input | 5 | Code value to store |
| rd_chan | input | CH_W | Global channel index for the read |
| rd_gate | input | 1 | 1 reads the gate code, 0 the clock code |
| rd_code | output | 5 | Registered read data |
| clk_pin | input | N | Per-channel clock pin input |
| gat_pin | input | N | Per-channel gate pin input |
| ext_clk | input | NUM_CHIPS | Shared external clock, one per chip |
| tbase_20m | input | 1 | 20 MHz time base |
| tbase_10m | input | 1 | 10 MHz time base |
| tbase_1m | input | 1 | 1 MHz time base |
| tbase_100k | input | 1 | 100 kHz time base |
| tbase_10k | input | 1 | 10 kHz time base |
| tbase_1k | input | 1 | 1 kHz time base |
| pat_present | input | 1 | Pattern currently present |
| pat_occurred | input | 1 | Latched pattern-occurred flag |
| pat_gone | input | 1 | Latched pattern-gone flag |
| ctr_out | input | N | Counter channel outputs for chaining |
| ctr_clk | output | N | Routed counter clocks (also the pin drive value) |
| ctr_gate | output | N | Routed counter gates (also the pin drive value) |
| clk_pin_oe | output | N | Clock pin driven as output |
| gat_pin_oe | output | N | Gate pin driven as output |

## Verification
A corrupted stored code shows up at the ports one cycle later, in up to three places:
- the affected channel's enable bit flips;
- its routed value follows the wrong source;
- a read-back returns a different value.

A wrong neighbour index is silent until the chained output differs from the correct one. For that reason the stimulus drives independent random values on every `ctr_out` bit and checks all channels each time. A mode decode error only appears for codes 6 and above, so those codes are written in both modes.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CODE_W      = 5;
  localparam int CH_PER_CHIP = 3;

  typedef enum logic [CODE_W-1:0] {
    CK_PIN   = 5'd0,
    CK_10M   = 5'd1,
    CK_1M    = 5'd2,
    CK_100K  = 5'd3,
    CK_10K   = 5'd4,
    CK_1K    = 5'd5,
    CK_CHAIN = 5'd6,
    CK_EXT   = 5'd7,
    CK_HIGH  = 5'd8,
    CK_LOW   = 5'd9,
    CK_PAT   = 5'd10,
    CK_20M   = 5'd11
  } clk_code_e;

  typedef enum logic [CODE_W-1:0] {
    GT_ON    = 5'd0,
    GT_OFF   = 5'd1,
    GT_PIN   = 5'd2,
    GT_NOUT  = 5'd3,
    GT_NPIN  = 5'd6,
    GT_OUT   = 5'd7,
    GT_PAT   = 5'd8,
    GT_OCC   = 5'd9,
    GT_GONE  = 5'd10,
    GT_NPAT  = 5'd11,
    GT_NOCC  = 5'd12,
    GT_NGONE = 5'd13
  } gate_code_e;

  typedef struct packed {
    logic f20m;
    logic f10m;
    logic f1m;
    logic f100k;
    logic f10k;
    logic f1k;
  } tbase_t;
endpackage

// File: rtl/csel_code_regs.sv
module csel_code_regs
  import csel_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int CH_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_gate,
  input  logic [CH_W-1:0]       wr_chan,
  input  logic [CODE_W-1:0]     wr_code,
  input  logic [CH_W-1:0]       rd_chan,
  input  logic                  rd_gate,
  output logic [CODE_W-1:0]     rd_code,
  output logic [NCH*CODE_W-1:0] clk_codes,
  output logic [NCH*CODE_W-1:0] gate_codes
);
  logic [CODE_W-1:0] ck_q [NCH];
  logic [CODE_W-1:0] gt_q [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        ck_q[i] <= '0;
        gt_q[i] <= '0;
      end
    end else if (wr_en && (int'(wr_chan) < NCH)) begin
      if (wr_gate) gt_q[wr_chan] <= wr_code;
      else         ck_q[wr_chan] <= wr_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      rd_code <= '0;
    else if (int'(rd_chan) >= NCH) rd_code <= '0;
    else if (rd_gate)             rd_code <= gt_q[rd_chan];
    else                          rd_code <= ck_q[rd_chan];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_flat
    assign clk_codes[i*CODE_W +: CODE_W]  = ck_q[i];
    assign gate_codes[i*CODE_W +: CODE_W] = gt_q[i];
  end
endmodule

// File: rtl/csel_clk_mux.sv
module csel_clk_mux
  import csel_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              enhanced,
  input  logic              pin,
  input  logic              ext,
  input  tbase_t            tb,
  input  logic              pat_present,
  input  logic              chain_out,
  output logic              sel
);
  always_comb begin
    sel = 1'b0;
    case (code)
      CK_PIN:   sel = pin;
      CK_10M:   sel = tb.f10m;
      CK_1M:    sel = tb.f1m;
      CK_100K:  sel = tb.f100k;
      CK_10K:   sel = tb.f10k;
      CK_1K:    sel = tb.f1k;
      CK_CHAIN: sel = chain_out;
      CK_EXT:   sel = ext;
      CK_HIGH:  sel = enhanced;
      CK_LOW:   sel = 1'b0;
      CK_PAT:   sel = enhanced & pat_present;
      CK_20M:   sel = enhanced & tb.f20m;
      default:  sel = 1'b0;
    endcase
  end
endmodule

// File: rtl/csel_gate_mux.sv
module csel_gate_mux
  import csel_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              enhanced,
  input  logic              pin,
  input  logic              chain_out,
  input  logic              pat_present,
  input  logic              pat_occurred,
  input  logic              pat_gone,
  output logic              sel
);
  always_comb begin
    sel = 1'b0;
    case (code)
      GT_ON:    sel = 1'b1;
      GT_OFF:   sel = 1'b0;
      GT_PIN:   sel = pin;
      GT_NOUT:  sel = ~chain_out;
      GT_NPIN:  sel = enhanced & ~pin;
      GT_OUT:   sel = enhanced & chain_out;
      GT_PAT:   sel = enhanced & pat_present;
      GT_OCC:   sel = enhanced & pat_occurred;
      GT_GONE:  sel = enhanced & pat_gone;
      GT_NPAT:  sel = enhanced & ~pat_present;
      GT_NOCC:  sel = enhanced & ~pat_occurred;
      GT_NGONE: sel = enhanced & ~pat_gone;
      default:  sel = 1'b0;
    endcase
  end
endmodule

// File: rtl/counter_src_select.sv
module counter_src_select
  import csel_pkg::*;
#(
  parameter int NUM_CHIPS = 2,
  parameter int NCH       = NUM_CHIPS * CH_PER_CHIP,
  parameter int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enhanced,
  input  logic                 wr_en,
  input  logic                 wr_gate,
  input  logic [CH_W-1:0]      wr_chan,
  input  logic [CODE_W-1:0]    wr_code,
  input  logic [CH_W-1:0]      rd_chan,
  input  logic                 rd_gate,
  output logic [CODE_W-1:0]    rd_code,
  input  logic [NCH-1:0]       clk_pin,
  input  logic [NCH-1:0]       gat_pin,
  input  logic [NUM_CHIPS-1:0] ext_clk,
  input  logic                 tbase_20m,
  input  logic                 tbase_10m,
  input  logic                 tbase_1m,
  input  logic                 tbase_100k,
  input  logic                 tbase_10k,
  input  logic                 tbase_1k,
  input  logic                 pat_present,
  input  logic                 pat_occurred,
  input  logic                 pat_gone,
  input  logic [NCH-1:0]       ctr_out,
  output logic [NCH-1:0]       ctr_clk,
  output logic [NCH-1:0]       ctr_gate,
  output logic [NCH-1:0]       clk_pin_oe,
  output logic [NCH-1:0]       gat_pin_oe
);
  logic [NCH*CODE_W-1:0] clk_codes;
  logic [NCH*CODE_W-1:0] gate_codes;
  logic [NCH-1:0]        clk_sel;
  logic [NCH-1:0]        gate_sel;
  logic [NCH-1:0]        ck_oe_d;
  logic [NCH-1:0]        gt_oe_d;
  tbase_t                tb;

  assign tb = '{f20m: tbase_20m, f10m: tbase_10m, f1m: tbase_1m,
                f100k: tbase_100k, f10k: tbase_10k, f1k: tbase_1k};

  csel_code_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_gate    (wr_gate),
    .wr_chan    (wr_chan),
    .wr_code    (wr_code),
    .rd_chan    (rd_chan),
    .rd_gate    (rd_gate),
    .rd_code    (rd_code),
    .clk_codes  (clk_codes),
    .gate_codes (gate_codes)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    // Ring neighbours: one below for clock chaining, two below for gate chaining.
    localparam int CHIP    = g / CH_PER_CHIP;
    localparam int NB_CLK  = (g + NCH - 1) % NCH;
    localparam int NB_GATE = (g + 2 * NCH - 2) % NCH;

    logic [CODE_W-1:0] ck_code;
    logic [CODE_W-1:0] gt_code;
    assign ck_code = clk_codes[g*CODE_W +: CODE_W];
    assign gt_code = gate_codes[g*CODE_W +: CODE_W];

    csel_clk_mux u_ck (
      .code        (ck_code),
      .enhanced    (enhanced),
      .pin         (clk_pin[g]),
      .ext         (ext_clk[CHIP]),
      .tb          (tb),
      .pat_present (pat_present),
      .chain_out   (ctr_out[NB_CLK]),
      .sel         (clk_sel[g])
    );

    csel_gate_mux u_gt (
      .code         (gt_code),
      .enhanced     (enhanced),
      .pin          (gat_pin[g]),
      .chain_out    (ctr_out[NB_GATE]),
      .pat_present  (pat_present),
      .pat_occurred (pat_occurred),
      .pat_gone     (pat_gone),
      .sel          (gate_sel[g])
    );

    assign ck_oe_d[g] = (ck_code != CK_PIN);
    assign gt_oe_d[g] = (gt_code != GT_PIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_clk    <= '0;
      ctr_gate   <= '1;
      clk_pin_oe <= '0;
      gat_pin_oe <= '1;
    end else begin
      ctr_clk    <= clk_sel;
      ctr_gate   <= gate_sel;
      clk_pin_oe <= ck_oe_d;
      gat_pin_oe <= gt_oe_d;
    end
  end
endmodule

// File: rtl/csel_checker.sv
module csel_checker
  import csel_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int CH_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  enhanced,
  input logic                  wr_en,
  input logic                  wr_gate,
  input logic [CH_W-1:0]       wr_chan,
  input logic [CODE_W-1:0]     wr_code,
  input logic [CH_W-1:0]       rd_chan,
  input logic                  rd_gate,
  input logic [CODE_W-1:0]     rd_code,
  input logic [NCH-1:0]        ctr_clk,
  input logic [NCH-1:0]        ctr_gate,
  input logic [NCH-1:0]        clk_pin_oe,
  input logic [NCH-1:0]        gat_pin_oe,
  input logic [NCH*CODE_W-1:0] clk_codes,
  input logic [NCH*CODE_W-1:0] gate_codes
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (clk_pin_oe == '0) && (gat_pin_oe == '1) && (ctr_gate == '1) && (ctr_clk == '0));

  a_r8_oe_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en, 2) |-> $stable(clk_pin_oe) && $stable(gat_pin_oe));

  a_r9_readback: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && (int'($past(wr_chan)) < NCH) &&
     (rd_chan == $past(wr_chan)) && (rd_gate == $past(wr_gate)))
    |=> (rd_code == $past(wr_code, 2)));

  a_r11_bad_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(wr_chan) >= NCH)) |=> $stable(clk_codes) && $stable(gate_codes));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    a_r3_base_clk_low: assert property (@(posedge clk) disable iff (rst)
      $past(!enhanced && (clk_codes[i*CODE_W +: CODE_W] >= 5'd8)) |-> !ctr_clk[i]);

    a_r4_gate_off: assert property (@(posedge clk) disable iff (rst)
      $past(gate_codes[i*CODE_W +: CODE_W] == 5'd1) |-> !ctr_gate[i]);

    a_r4_gate_on: assert property (@(posedge clk) disable iff (rst)
      $past(gate_codes[i*CODE_W +: CODE_W] == 5'd0) |-> ctr_gate[i]);
  end
endmodule

bind counter_src_select csel_checker #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enhanced   (enhanced),
  .wr_en      (wr_en),
  .wr_gate    (wr_gate),
  .wr_chan    (wr_chan),
  .wr_code    (wr_code),
  .rd_chan    (rd_chan),
  .rd_gate    (rd_gate),
  .rd_code    (rd_code),
  .ctr_clk    (ctr_clk),
  .ctr_gate   (ctr_gate),
  .clk_pin_oe (clk_pin_oe),
  .gat_pin_oe (gat_pin_oe),
  .clk_codes  (clk_codes),
  .gate_codes (gate_codes)
);

// File: tb/tb_counter_src_select.sv
module tb_counter_src_select;
  localparam int NCHIP = 2;
  localparam int N     = 6;
  localparam int CW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enhanced = 1'b0;
  logic wr_en = 1'b0, wr_gate = 1'b0, rd_gate = 1'b0;
  logic [CW-1:0] wr_chan = '0, rd_chan = '0;
  logic [4:0] wr_code = '0;
  logic [4:0] rd_code;
  logic [N-1:0] clk_pin = '0, gat_pin = '0, ctr_out = '0;
  logic [NCHIP-1:0] ext_clk = '0;
  logic t20 = 0, t10 = 0, t1 = 0, t100k = 0, t10k = 0, t1k = 0;
  logic pp = 0, po = 0, pg = 0;
  logic [N-1:0] ctr_clk, ctr_gate, clk_pin_oe, gat_pin_oe;

  counter_src_select #(.NUM_CHIPS(NCHIP)) dut (
    .clk(clk), .rst(rst), .enhanced(enhanced),
    .wr_en(wr_en), .wr_gate(wr_gate), .wr_chan(wr_chan), .wr_code(wr_code),
    .rd_chan(rd_chan), .rd_gate(rd_gate), .rd_code(rd_code),
    .clk_pin(clk_pin), .gat_pin(gat_pin), .ext_clk(ext_clk),
    .tbase_20m(t20), .tbase_10m(t10), .tbase_1m(t1), .tbase_100k(t100k),
    .tbase_10k(t10k), .tbase_1k(t1k),
    .pat_present(pp), .pat_occurred(po), .pat_gone(pg),
    .ctr_out(ctr_out), .ctr_clk(ctr_clk), .ctr_gate(ctr_gate),
    .clk_pin_oe(clk_pin_oe), .gat_pin_oe(gat_pin_oe)
  );

  always #5ns clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [4:0] mck [N];
  logic [4:0] mgt [N];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int prev_chip(input int c);
    return (c + NCHIP - 1) % NCHIP;
  endfunction

  function automatic logic exp_clk(input int i);
    int chip = i / 3, pos = i % 3;
    int nb = (pos > 0) ? i - 1 : prev_chip(chip) * 3 + 2;
    case (mck[i])
      0: return clk_pin[i];
      1: return t10;
      2: return t1;
      3: return t100k;
      4: return t10k;
      5: return t1k;
      6: return ctr_out[nb];
      7: return ext_clk[chip];
      8: return enhanced;
      10: return enhanced & pp;
      11: return enhanced & t20;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_gate(input int i);
    int chip = i / 3, pos = i % 3;
    int nb = (pos == 2) ? chip * 3 : prev_chip(chip) * 3 + pos + 1;
    case (mgt[i])
      0: return 1'b1;
      1: return 1'b0;
      2: return gat_pin[i];
      3: return ~ctr_out[nb];
      6: return enhanced & ~gat_pin[i];
      7: return enhanced & ctr_out[nb];
      8: return enhanced & pp;
      9: return enhanced & po;
      10: return enhanced & pg;
      11: return enhanced & ~pp;
      12: return enhanced & ~po;
      13: return enhanced & ~pg;
      default: return 1'b0;
    endcase
  endfunction

  // Called at a negedge; the write lands on the next posedge.
  task automatic do_write(input int ch, input bit g, input int code);
    wr_en = 1; wr_gate = g; wr_chan = CW'(ch); wr_code = 5'(code);
    @(negedge clk);
    wr_en = 0;
    if (ch < N) begin
      if (g) mgt[ch] = 5'(code);
      else   mck[ch] = 5'(code);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < N; i++) begin
      chk(ctr_clk[i] == exp_clk(i), {tag, " R2/R3/R6 clk"}, int'(ctr_clk[i]), int'(exp_clk(i)));
      chk(ctr_gate[i] == exp_gate(i), {tag, " R4/R5/R7 gate"}, int'(ctr_gate[i]), int'(exp_gate(i)));
      chk(clk_pin_oe[i] == (mck[i] != 0), "R8 clk_oe", int'(clk_pin_oe[i]), int'(mck[i] != 0));
      chk(gat_pin_oe[i] == (mgt[i] != 2), "R8 gat_oe", int'(gat_pin_oe[i]), int'(mgt[i] != 2));
    end
  endtask

  task automatic rand_inputs();
    clk_pin = N'($urandom); gat_pin = N'($urandom); ctr_out = N'($urandom);
    ext_clk = NCHIP'($urandom);
    {t20, t10, t1, t100k, t10k, t1k} = 6'($urandom);
    {pp, po, pg} = 3'($urandom);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin mck[i] = 0; mgt[i] = 0; end
    rand_inputs();
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(ctr_clk == '0, "R1 clk", int'(ctr_clk), 0);
    chk(ctr_gate == '1, "R1 gate", int'(ctr_gate), 63);
    chk(clk_pin_oe == '0, "R1 clk_oe", int'(clk_pin_oe), 0);
    chk(gat_pin_oe == '1, "R1 gat_oe", int'(gat_pin_oe), 63);
    rst = 0;
    @(negedge clk);
    check_all("R1 after reset");

    // R10: input change visible only after one edge
    clk_pin[0] = ~clk_pin[0];
    #1ns;
    chk(ctr_clk[0] != clk_pin[0], "R10 before edge", int'(ctr_clk[0]), int'(~clk_pin[0]));
    @(negedge clk);
    chk(ctr_clk[0] == clk_pin[0], "R10 after edge", int'(ctr_clk[0]), int'(clk_pin[0]));

    // R6 ring: channel 0 clock chains from channel 5
    do_write(0, 0, 6);
    ctr_out = 6'b100000;
    @(negedge clk); @(negedge clk);
    chk(ctr_clk[0] == 1'b1, "R6 ring clk ch0", int'(ctr_clk[0]), 1);
    // R7 ring: channel 1 gate from channel 5 inverted; channel 2 from channel 0
    do_write(1, 1, 3);
    do_write(2, 1, 3);
    ctr_out = 6'b000001;
    @(negedge clk); @(negedge clk);
    chk(ctr_gate[1] == 1'b1, "R7 ring gate ch1", int'(ctr_gate[1]), 1);
    chk(ctr_gate[2] == 1'b0, "R7 gate ch2", int'(ctr_gate[2]), 0);

    // R3: enhanced-only code is low in base mode
    enhanced = 0;
    do_write(3, 0, 8);
    @(negedge clk);
    chk(ctr_clk[3] == 1'b0, "R3 base code 8", int'(ctr_clk[3]), 0);
    enhanced = 1;
    @(negedge clk);
    chk(ctr_clk[3] == 1'b1, "R3 enhanced code 8", int'(ctr_clk[3]), 1);

    // R11: invalid write ignored, invalid read gives 0
    do_write(6, 0, 9);
    do_write(7, 1, 9);
    rd_chan = 3'd6; rd_gate = 0;
    @(negedge clk);
    chk(rd_code == 5'd0, "R11 bad read", int'(rd_code), 0);
    check_all("R11 bad write");

    // R9: readback of an out-of-range code
    do_write(4, 1, 31);
    rd_chan = 3'd4; rd_gate = 1;
    @(negedge clk);
    chk(rd_code == 5'd31, "R9 readback", int'(rd_code), 31);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      rand_inputs();
      enhanced = 1'($urandom);
      rd_chan = CW'($urandom_range(0, N - 1));
      rd_gate = 1'($urandom);
      if ($urandom_range(0, 3) != 0)
        do_write($urandom_range(0, 7), 1'($urandom), $urandom_range(0, 31));
      else
        @(negedge clk);
      @(negedge clk);
      check_all("rand");
      chk(rd_code == (rd_gate ? mgt[rd_chan] : mck[rd_chan]), "R9 rand readback",
          int'(rd_code), int'(rd_gate ? mgt[rd_chan] : mck[rd_chan]));
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule